// File: doc/BRIEF.md
# ONFI Fast Asynchronous Timing-Mode Enable Sequencer

This block runs once after a NAND device has been identified, to move that device into the fastest asynchronous timing mode it supports. It takes a supported-mode bitmask and picks mode 5 or, if mode 5 is missing, mode 4. No other mode is ever used. The block then selects the chip and writes the timing-mode feature with a SET FEATURES command. It waits for the device's ready/busy line and reads the same feature back with a GET FEATURES command. It compares the first returned byte with the mode it asked for.

If the compare matches, the block raises a persistent extended-data-out enable flag, reports the chosen mode and requests a controller clock rate that suits that mode. If no usable mode exists, the block finishes at once without an error and leaves the device untouched. If the compare fails, or if the device never becomes ready in time, the block reports a failure, leaves the fast mode off, and the controller carries on with its normal timing.

Bytes leave the block on a valid/ready stream. Each byte is tagged as a command, an address or a data byte. The block holds `tx_valid`, `tx_byte` and `tx_kind` steady until the device side accepts the byte with `tx_ready`. Read-back bytes enter on a second valid/ready stream, and the block raises `rx_ready` only while it expects read data. Either side may stall for any number of cycles. Control and status pins are plain levels or pulses.

Top module: `onfi_mode_seq`

## Requirements
- R1: On a start pulse while idle, mask bit 5 selects mode 5. Otherwise mask bit 4 selects mode 4. All other mask bits have no effect on the choice.
- R2: If neither mask bit 4 nor mask bit 5 is set, the block sends no byte and never raises `ce`. One cycle after the start it pulses `done` with `fail`=0 and with `edo_en`, `mode_out` and `clk_req_mhz` all 0.
- R3: The write phase sends six bytes in this order: command 0xEF, address 0x01, then four data bytes (mode, 0, 0, 0). The tags are 0 for a command, 1 for an address and 2 for data.
- R4: After the write phase the block waits for `rb`=1, ignoring the first GUARD_CYC cycles. It then sends command 0xEE and address 0x01, waits for `rb`=1 the same way, and reads four bytes. Only the first byte is compared with the mode.
- R5: On a match, `done` pulses with `fail`=0, `edo_en`=1 and `mode_out` equal to the chosen mode. `clk_req_mhz` is 100 for mode 5 and 80 for mode 4. These values hold until the next run ends.
- R6: On a mismatch, `done` pulses with `fail`=1, and `edo_en`, `mode_out` and `clk_req_mhz` become 0.
- R7: If `rb` stays low for TMO_CYC cycles in either wait, the block ends with the R6 failure outcome and sends no further byte.
- R8: `ce` is 1 on every accepted output byte and every accepted read byte. It is 0 in the `done` cycle and while idle, on both the pass and the fail paths.
- R9: A start pulse during a run is ignored. Each run gives exactly one `done` pulse, one cycle long.
- R10: While `tx_valid`=1 and `tx_ready`=0, the next cycle keeps `tx_valid`=1 with the same `tx_byte` and `tx_kind`.
- R11: After reset, `done`, `ce`, `tx_valid`, `rx_ready`, `edo_en`, `mode_out` and `clk_req_mhz` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| mode_mask | input | MASK_W | Supported asynchronous modes, bit n means mode n |
| rb | input | 1 | Device ready/busy, 1 means ready |
| ce | output | 1 | Chip select, active high |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Device side accepts the output byte |
| tx_kind | output | 2 | Byte tag: 0 command, 1 address, 2 data |
| tx_byte | output | 8 | Output byte |
| rx_valid | input | 1 | Read byte valid |
| rx_ready | output | 1 | Block accepts a read byte |
| rx_byte | input | 8 | Read byte |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Status of the last run, 1 on failure |
| edo_en | output | 1 | Fast extended-data-out mode enabled |
| mode_out | output | 3 | Mode in use, 0 when disabled |
| clk_req_mhz | output | 8 | Requested controller clock in MHz, 0 when disabled |

## Verification
The bench sweeps all 64 patterns of the low six mask bits against five device behaviours:

- a clean device;
- a device that stalls both streams;
- a device that echoes a wrong mode;
- a device that stays busy after the write;
- a device that stays busy after the read command.

A design that gave mode 4 priority would send the wrong data byte and request 80 MHz when both mode bits are set. One that ignored the read-back would enable fast mode on the corrupted echo. One that lacked the timeout would hang. Runs follow one another without reset, so a fail that did not clear the enable flag left over from an earlier pass is caught. A start pulse during a run checks that a second sequence is not launched. A design that advanced on a stalled byte would drop or repeat bytes in the logged stream.

// File: rtl/onfi_seq_pkg.sv
package onfi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SET_TX,
    ST_SET_WAIT,
    ST_GET_TX,
    ST_GET_WAIT,
    ST_GET_RX,
    ST_FINISH
  } seq_st_t;

  typedef enum logic [1:0] {
    BK_CMD  = 2'd0,
    BK_ADDR = 2'd1,
    BK_DATA = 2'd2
  } byte_kind_t;

  localparam logic [7:0] OP_FEAT_WRITE = 8'hEF;
  localparam logic [7:0] OP_FEAT_READ  = 8'hEE;
  localparam logic [7:0] FEAT_TMODE    = 8'h01;

endpackage

// File: rtl/onfi_mode_pick.sv
module onfi_mode_pick #(
  parameter int MASK_W = 8
) (
  input  logic [MASK_W-1:0] mask,
  output logic              found,
  output logic [2:0]        mode
);
  // only the two fastest modes are candidates; mode 5 wins
  logic unused_mask;
  assign unused_mask = ^mask;

  always_comb begin
    found = 1'b1;
    mode  = 3'd0;
    if (mask[5])      mode = 3'd5;
    else if (mask[4]) mode = 3'd4;
    else              found = 1'b0;
  end
endmodule

// File: rtl/onfi_rb_wait.sv
module onfi_rb_wait #(
  parameter int GUARD_CYC = 2,
  parameter int TMO_CYC   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rb,
  output logic ready_ok,
  output logic timed_out
);
  localparam int CW = $clog2(TMO_CYC + 1) + 1;

  logic [CW-1:0] cnt;
  logic          guard_over;
  logic          limit_hit;

  assign guard_over = cnt >= CW'(GUARD_CYC);
  assign limit_hit  = cnt >= CW'(TMO_CYC);
  assign ready_ok   = active && guard_over && rb;
  assign timed_out  = active && limit_hit && !ready_ok;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) cnt <= '0;
    else if (!limit_hit)   cnt <= cnt + 1'b1;
  end

  // R7
  property tmo_only_busy;
    @(posedge clk) disable iff (!rst_n) timed_out |-> !rb;
  endproperty
  tmo_only_busy_chk: assert property (tmo_only_busy);
endmodule

// File: rtl/onfi_byte_gen.sv
module onfi_byte_gen
  import onfi_seq_pkg::*;
#(
  parameter int PARAM_BYTES = 4,
  parameter int IDXW = $clog2(PARAM_BYTES + 2)
) (
  input  logic            is_get,
  input  logic [IDXW-1:0] idx,
  input  logic [2:0]      mode,
  output byte_kind_t      kind,
  output logic [7:0]      data,
  output logic            last
);
  always_comb begin
    last = is_get ? (idx == IDXW'(1)) : (idx == IDXW'(PARAM_BYTES + 1));
    if (idx == '0) begin
      kind = BK_CMD;
      data = is_get ? OP_FEAT_READ : OP_FEAT_WRITE;
    end else if (idx == IDXW'(1)) begin
      kind = BK_ADDR;
      data = FEAT_TMODE;
    end else begin
      kind = BK_DATA;
      data = (idx == IDXW'(2)) ? {5'd0, mode} : 8'd0;
    end
  end
endmodule

// File: rtl/onfi_mode_seq.sv
module onfi_mode_seq
  import onfi_seq_pkg::*;
#(
  parameter int MASK_W      = 8,
  parameter int PARAM_BYTES = 4,
  parameter int GUARD_CYC   = 2,
  parameter int TMO_CYC     = 1000,
  parameter int FAST_MHZ    = 100,
  parameter int SLOW_MHZ    = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MASK_W-1:0] mode_mask,
  input  logic              rb,
  output logic              ce,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [1:0]        tx_kind,
  output logic [7:0]        tx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_byte,
  output logic              done,
  output logic              fail,
  output logic              edo_en,
  output logic [2:0]        mode_out,
  output logic [7:0]        clk_req_mhz
);
  localparam int IDXW = $clog2(PARAM_BYTES + 2);

  seq_st_t         st;
  logic [IDXW-1:0] idx;
  logic [2:0]      mode_q;
  logic [7:0]      first_q;

  logic            pick_found;
  logic [2:0]      pick_mode;
  logic            wait_act, wait_ok, wait_tmo;
  byte_kind_t      gen_kind;
  logic [7:0]      gen_data;
  logic            gen_last;
  logic            echo_ok;
  logic            last_rx;

  onfi_mode_pick #(.MASK_W(MASK_W)) u_pick (
    .mask (mode_mask),
    .found(pick_found),
    .mode (pick_mode)
  );

  assign wait_act = (st == ST_SET_WAIT) || (st == ST_GET_WAIT);

  onfi_rb_wait #(.GUARD_CYC(GUARD_CYC), .TMO_CYC(TMO_CYC)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (wait_act),
    .rb       (rb),
    .ready_ok (wait_ok),
    .timed_out(wait_tmo)
  );

  onfi_byte_gen #(.PARAM_BYTES(PARAM_BYTES), .IDXW(IDXW)) u_gen (
    .is_get(st == ST_GET_TX),
    .idx   (idx),
    .mode  (mode_q),
    .kind  (gen_kind),
    .data  (gen_data),
    .last  (gen_last)
  );

  assign tx_valid = (st == ST_SET_TX) || (st == ST_GET_TX);
  assign tx_kind  = gen_kind;
  assign tx_byte  = gen_data;
  assign rx_ready = (st == ST_GET_RX);
  assign ce       = (st != ST_IDLE) && (st != ST_FINISH);
  assign done     = (st == ST_FINISH);
  assign last_rx  = (idx == IDXW'(PARAM_BYTES - 1));
  assign echo_ok  = (((idx == '0) ? rx_byte : first_q) == {5'd0, mode_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      idx         <= '0;
      mode_q      <= '0;
      first_q     <= '0;
      fail        <= 1'b0;
      edo_en      <= 1'b0;
      mode_out    <= '0;
      clk_req_mhz <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          idx <= '0;
          if (start) begin
            if (pick_found) begin
              mode_q <= pick_mode;
              st     <= ST_SET_TX;
            end else begin
              fail        <= 1'b0;
              edo_en      <= 1'b0;
              mode_out    <= '0;
              clk_req_mhz <= '0;
              st          <= ST_FINISH;
            end
          end
        end
        ST_SET_TX, ST_GET_TX: begin
          if (tx_ready) begin
            if (gen_last) begin
              idx <= '0;
              st  <= (st == ST_SET_TX) ? ST_SET_WAIT : ST_GET_WAIT;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_SET_WAIT, ST_GET_WAIT: begin
          if (wait_ok) begin
            st <= (st == ST_SET_WAIT) ? ST_GET_TX : ST_GET_RX;
          end else if (wait_tmo) begin
            fail        <= 1'b1;
            edo_en      <= 1'b0;
            mode_out    <= '0;
            clk_req_mhz <= '0;
            st          <= ST_FINISH;
          end
        end
        ST_GET_RX: begin
          if (rx_valid) begin
            if (idx == '0) first_q <= rx_byte;
            if (last_rx) begin
              fail        <= !echo_ok;
              edo_en      <= echo_ok;
              mode_out    <= echo_ok ? mode_q : 3'd0;
              clk_req_mhz <= !echo_ok ? 8'd0 :
                             (mode_q == 3'd5) ? 8'(FAST_MHZ) : 8'(SLOW_MHZ);
              st          <= ST_FINISH;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  property done_single;
    @(posedge clk) disable iff (!rst_n) done |=> !done;
  endproperty
  done_single_chk: assert property (done_single);

  // R8
  property ce_off_at_done;
    @(posedge clk) disable iff (!rst_n) done |-> !ce;
  endproperty
  ce_off_at_done_chk: assert property (ce_off_at_done);

  // R10
  property tx_hold;
    @(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_kind));
  endproperty
  tx_hold_chk: assert property (tx_hold);

  // R5
  property edo_moves_at_done;
    @(posedge clk) disable iff (!rst_n) !$stable(edo_en) |-> done;
  endproperty
  edo_moves_at_done_chk: assert property (edo_moves_at_done);

  // R5
  property edo_rate_match;
    @(posedge clk) disable iff (!rst_n)
      edo_en |-> ((mode_out == 3'd5 && clk_req_mhz == 8'(FAST_MHZ)) ||
                  (mode_out == 3'd4 && clk_req_mhz == 8'(SLOW_MHZ)));
  endproperty
  edo_rate_match_chk: assert property (edo_rate_match);

  // R6
  property fail_clears_edo;
    @(posedge clk) disable iff (!rst_n) (done && fail) |-> !edo_en;
  endproperty
  fail_clears_edo_chk: assert property (fail_clears_edo);
endmodule

// File: tb/sim_onfi_mode_seq.sv
module sim_onfi_mode_seq;
  localparam int TMO = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] mode_mask = '0;
  logic       rb = 1'b1;
  logic       ce, tx_valid, tx_ready, rx_ready, rx_valid, done, fail, edo_en;
  logic [1:0] tx_kind;
  logic [7:0] tx_byte, rx_byte, clk_req_mhz;
  logic [2:0] mode_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  onfi_mode_seq #(.TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_mask(mode_mask), .rb(rb),
    .ce(ce), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_kind(tx_kind),
    .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .done(done), .fail(fail), .edo_en(edo_en), .mode_out(mode_out),
    .clk_req_mhz(clk_req_mhz)
  );

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int mask, input int scen);
    int  exp_mode, cnt, busy, rx_left, dones, post, cyc;
    bit  stuck, ce_bad, saw_ce, exp_fail;
    logic [7:0] stored;
    logic [7:0] lb[8];
    logic [1:0] lk[8];
    logic [7:0] eb[8];
    logic [1:0] ek[8];
    int  exp_cnt;
    int  got_fail, got_edo, got_mode, got_clk, got_ce;

    exp_mode = mask[5] ? 5 : (mask[4] ? 4 : 0);
    exp_fail = (exp_mode != 0) && (scen >= 2);
    exp_cnt  = (exp_mode == 0) ? 0 : ((scen == 3) ? 6 : 8);
    eb = '{8'hEF, 8'h01, 8'(exp_mode), 8'h00, 8'h00, 8'h00, 8'hEE, 8'h01};
    ek = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd2, 2'd2, 2'd0, 2'd1};
    cnt = 0; busy = 0; rx_left = 0; dones = 0; post = -1; stuck = 0;
    ce_bad = 0; saw_ce = 0; stored = 8'h00;
    got_fail = 0; got_edo = 0; got_mode = 0; got_clk = 0; got_ce = 0;

    @(negedge clk);
    rb = 1'b1; mode_mask = 8'(mask); start = 1'b1; tx_ready = 1'b1; rx_valid = 1'b0;
    for (cyc = 1; cyc < 400 && post != 0; cyc++) begin
      @(negedge clk);
      if (post > 0) post--;
      // R9: second start mid-run must be ignored
      start = (scen == 1 && exp_mode != 0 && cyc == 5);
      if (done) begin
        dones++;
        if (dones == 1) begin
          got_fail = fail; got_edo = edo_en; got_mode = mode_out;
          got_clk = clk_req_mhz; got_ce = ce; post = 4;
        end
      end
      if (ce) saw_ce = 1;
      if (busy > 0) begin rb = 1'b0; busy--; end
      else rb = !stuck;
      tx_ready = (scen == 1) ? (cyc % 3 != 0) : 1'b1;
      if (tx_valid && tx_ready) begin
        if (!ce) ce_bad = 1;
        if (cnt < 8) begin lb[cnt] = tx_byte; lk[cnt] = tx_kind; end
        if (cnt == 2) stored = tx_byte;
        if (cnt == 5) begin busy = 3; stuck = (scen == 3); end
        if (cnt == 7) begin busy = 2; stuck = (scen == 4); rx_left = 4; end
        cnt++;
      end
      rx_valid = (rx_left > 0) && rb && (scen != 1 || cyc % 2 == 1);
      rx_byte  = (rx_left == 4) ? ((scen == 2) ? (stored ^ 8'h01) : stored) : 8'h00;
      if (rx_valid && rx_ready) begin
        if (!ce) ce_bad = 1;
        rx_left--;
      end
    end
    start = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0;

    chk(dones == 1, "R9 done count", dones, 1);
    chk(got_fail == int'(exp_fail), "R6/R7 fail status", got_fail, int'(exp_fail));
    chk(got_edo == int'(exp_mode != 0 && !exp_fail), "R5 edo_en", got_edo,
        int'(exp_mode != 0 && !exp_fail));
    chk(got_mode == (exp_fail ? 0 : exp_mode), "R1 mode_out", got_mode,
        exp_fail ? 0 : exp_mode);
    chk(got_clk == ((exp_fail || exp_mode == 0) ? 0 : (exp_mode == 5 ? 100 : 80)),
        "R5 clk_req", got_clk,
        (exp_fail || exp_mode == 0) ? 0 : (exp_mode == 5 ? 100 : 80));
    chk(cnt == exp_cnt, "R3/R4/R7 byte count", cnt, exp_cnt);
    for (int i = 0; i < 8; i++) begin
      if (i < exp_cnt && i < cnt) begin
        chk(lb[i] == eb[i], "R3/R4 byte value", lb[i], eb[i]);
        chk(lk[i] == ek[i], "R3 byte tag", lk[i], ek[i]);
      end
    end
    chk(got_ce == 0, "R8 ce at done", got_ce, 0);
    chk(!ce_bad, "R8 ce during transfer", int'(ce_bad), 0);
    if (exp_mode == 0) chk(!saw_ce, "R2 ce never raised", int'(saw_ce), 0);
    chk(ce == 0, "R8 ce idle", ce, 0);
  endtask

  initial begin
    tx_ready = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(done == 0 && ce == 0 && tx_valid == 0 && rx_ready == 0, "R11 control reset",
        {done, ce, tx_valid, rx_ready}, 0);
    chk(edo_en == 0 && mode_out == 0 && clk_req_mhz == 0, "R11 status reset",
        {edo_en, mode_out, clk_req_mhz}, 0);
    rst_n = 1'b1;
    for (int sc = 0; sc < 5; sc++)
      for (int m = 0; m < 64; m++)
        run(m, sc);
    // R1: upper bits do not alter the choice
    run(8'hC0, 0);
    run(8'hD0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule